// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider

This block is the programmable divide chain of a PLL frequency synthesizer built around a 64/65 dual-modulus prescaler. It runs on the prescaler output. A 10-bit main count N and a 6-bit swallow count A set how many prescaler pulses make up one period. During the first A prescaler pulses of each period, the modulus-control output asks the prescaler for division by 65. For the remaining pulses it asks for 64. The total VCO division is therefore 64·N + A. To reach a required divisor D, set N to the integer part of D/64 and A to the remainder. For example, D = 29268 gives N = 457 and A = 20, and D = 40888 gives N = 638 and A = 56.

A second counter on the reference oscillator clock produces the comparison pulse for the phase detector. A 3-bit select picks its divisor from a fixed set:

- Select 0 uses a divisor that depends on the path: 3168 for transmit and 2112 for receive.
- Select 7 marks the channel as unusable. It raises a disable flag and silences both pulse outputs.

Top module: `pll_swallow_div`

## Requirements
- R1: Over each VCO-pulse period, the prescaler-clock cycles weighted 65 when `mod_sel_o` is 1 and 64 when it is 0 sum to 64·N + A.
- R2: Within each period, `mod_sel_o` is 1 for exactly the first A prescaler cycles, starting with the cycle in which `vco_pulse_o` is high. It is 0 for the other N − A cycles.
- R3: `vco_pulse_o` is high for one prescaler cycle per period, and consecutive pulses are N prescaler cycles apart.
- R4: N and A are sampled only at the counter reload that raises `vco_pulse_o`. A pair with N = 0 or A > N is not taken, and the previously loaded pair stays in effect.
- R5: The reference divisor depends on `ref_sel_i`: 1 gives 3168, 2 gives 2640, 3 gives 2112, 4 gives 3312, 5 gives 2760 and 6 gives 2208. The divisor is the number of reference-clock cycles between `ref_pulse_o` pulses.
- R6: With `ref_sel_i` = 0 the reference divisor is 3168 when `tx_i` = 1 and 2112 when `tx_i` = 0.
- R7: With `ref_sel_i` = 7, `chan_off_o` is 1 and both `vco_pulse_o` and `ref_pulse_o` stay 0. The last valid reference divisor is kept and is replaced when a valid select returns.
- R8: While reset is asserted, `mod_sel_o`, `vco_pulse_o` and `ref_pulse_o` are 0.
- R9: `ref_pulse_o` is high for exactly one reference-clock cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pre_clk_i | input | 1 | Prescaler output, clocks the swallow and main counters |
| ref_clk_i | input | 1 | Reference oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| n_i | input | 10 | Main count N |
| a_i | input | 6 | Swallow count A |
| ref_sel_i | input | 3 | Reference divisor select |
| tx_i | input | 1 | Path select for code 0: 1 transmit, 0 receive |
| mod_sel_o | output | 1 | Modulus control, 1 = divide by 65 |
| vco_pulse_o | output | 1 | Divided VCO pulse, one prescaler cycle wide |
| ref_pulse_o | output | 1 | Divided reference pulse, one reference cycle wide |
| chan_off_o | output | 1 | Channel disabled flag |

## Verification
The bench builds the block with its default widths: N_W = 10 and A_W = 6. With these widths it can reach the largest swallow count, A = 63, with N = A. It also exercises the degenerate N = 1 periods, in which the pulse never falls, and both worked divisors, 29268 and 40888. The reference divisors are only a few thousand cycles long, so every select code, including both paths of code 0, is measured over a full period at its real size.

// File: rtl/syn_div_pkg.sv
`timescale 1ns/1ps
package syn_div_pkg;
  localparam int unsigned REF_W = 12;
  typedef logic [REF_W-1:0] ref_div_t;

  localparam ref_div_t DIV_S1 = ref_div_t'(3168);
  localparam ref_div_t DIV_S2 = ref_div_t'(2640);
  localparam ref_div_t DIV_S3 = ref_div_t'(2112);
  localparam ref_div_t DIV_S4 = ref_div_t'(3312);
  localparam ref_div_t DIV_S5 = ref_div_t'(2760);
  localparam ref_div_t DIV_S6 = ref_div_t'(2208);

  typedef enum logic [2:0] {
    SEL_PATH = 3'd0,
    SEL_OFF  = 3'd7
  } ref_sel_e;
endpackage

// File: rtl/swallow_ctr.sv
`timescale 1ns/1ps
module swallow_ctr #(
  parameter int unsigned N_W = 10,
  parameter int unsigned A_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  output logic           mod_o,
  output logic           tick_o
);
  logic [N_W-1:0] n_q, n_cnt, n_nx;
  logic [A_W-1:0] a_q, a_cnt, a_nx;
  logic           reload, set_ok;

  assign reload = (n_cnt == '0);
  assign set_ok = (n_i != '0) && (N_W'(a_i) <= n_i);
  assign n_nx   = set_ok ? n_i : n_q;
  assign a_nx   = set_ok ? a_i : a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= N_W'(1);
      a_q    <= '0;
      n_cnt  <= '0;
      a_cnt  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= reload;
      if (reload) begin
        n_q   <= n_nx;
        a_q   <= a_nx;
        n_cnt <= n_nx - 1'b1;
        a_cnt <= a_nx;
      end else begin
        n_cnt <= n_cnt - 1'b1;
        if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
      end
    end
  end

  assign mod_o = (a_cnt != '0);

  // R2
  a_le_n_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({{(N_W+1-A_W){1'b0}}, a_cnt} <= ({1'b0, n_cnt} + 1'b1)));
  // R2
  swallow_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && a_cnt != '0) |=> (a_cnt == $past(a_cnt) - 1'b1));
  // R4
  loaded_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q != '0) && (N_W'(a_q) <= n_q));
endmodule

// File: rtl/ref_lut.sv
`timescale 1ns/1ps
module ref_lut
  import syn_div_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       tx_i,
  output ref_div_t   div_o,
  output logic       off_o
);
  always_comb begin
    off_o = 1'b0;
    unique case (sel_i)
      SEL_PATH: div_o = tx_i ? DIV_S1 : DIV_S3;
      3'd1:     div_o = DIV_S1;
      3'd2:     div_o = DIV_S2;
      3'd3:     div_o = DIV_S3;
      3'd4:     div_o = DIV_S4;
      3'd5:     div_o = DIV_S5;
      3'd6:     div_o = DIV_S6;
      default: begin
        div_o = DIV_S1;
        off_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ref_div.sv
`timescale 1ns/1ps
module ref_div
  import syn_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ref_div_t div_i,
  input  logic     off_i,
  output logic     tick_o
);
  ref_div_t div_q, cnt_q;
  logic     reload;

  assign reload = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_S1;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= reload;
      if (reload) begin
        if (!off_i) begin
          div_q <= div_i;
          cnt_q <= div_i - 1'b1;
        end else begin
          cnt_q <= div_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R9
  ref_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R5
  ref_div_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == DIV_S1) || (div_q == DIV_S2) || (div_q == DIV_S3) ||
    (div_q == DIV_S4) || (div_q == DIV_S5) || (div_q == DIV_S6));
endmodule

// File: rtl/pll_swallow_div.sv
`timescale 1ns/1ps
module pll_swallow_div
  import syn_div_pkg::*;
#(
  parameter int unsigned N_W = 10,
  parameter int unsigned A_W = 6
) (
  input  logic           pre_clk_i,
  input  logic           ref_clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic [2:0]     ref_sel_i,
  input  logic           tx_i,
  output logic           mod_sel_o,
  output logic           vco_pulse_o,
  output logic           ref_pulse_o,
  output logic           chan_off_o
);
  logic     vco_tick, ref_tick, off;
  ref_div_t div_sel;

  swallow_ctr #(.N_W(N_W), .A_W(A_W)) u_swallow (
    .clk_i  (pre_clk_i),
    .rst_ni (rst_ni),
    .n_i    (n_i),
    .a_i    (a_i),
    .mod_o  (mod_sel_o),
    .tick_o (vco_tick)
  );

  ref_lut u_lut (
    .sel_i (ref_sel_i),
    .tx_i  (tx_i),
    .div_o (div_sel),
    .off_o (off)
  );

  ref_div u_ref (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_sel),
    .off_i  (off),
    .tick_o (ref_tick)
  );

  assign chan_off_o  = off;
  assign vco_pulse_o = vco_tick & ~off;
  assign ref_pulse_o = ref_tick & ~off;

  // R8
  reset_quiet_chk: assert property (@(posedge ref_clk_i)
    !rst_ni |-> (!ref_pulse_o && !mod_sel_o && !vco_pulse_o));
endmodule

// File: tb/pll_swallow_div_test.sv
`timescale 1ns/1ps
module pll_swallow_div_test;
  logic pre_clk = 0, ref_clk = 0, rst_n = 0;
  logic [9:0] n_v = 10'd1;
  logic [5:0] a_v = 6'd0;
  logic [2:0] sel = 3'd1;
  logic tx = 1'b1;
  logic mod_sel, vco_pulse, ref_pulse, chan_off;
  int checks = 0, fails = 0, ref_cycles = 0;

  always #3 pre_clk = ~pre_clk;
  always #5 ref_clk = ~ref_clk;

  pll_swallow_div uut (
    .pre_clk_i(pre_clk), .ref_clk_i(ref_clk), .rst_ni(rst_n),
    .n_i(n_v), .a_i(a_v), .ref_sel_i(sel), .tx_i(tx),
    .mod_sel_o(mod_sel), .vco_pulse_o(vco_pulse),
    .ref_pulse_o(ref_pulse), .chan_off_o(chan_off)
  );

  // stimulus N, A, expected total, expected N period, expected A count
  localparam int NV = 9;
  localparam int VN[NV] = '{457, 638, 10, 63,   2,   1,  1, 20, 64};
  localparam int VA[NV] = '{ 20,  56,  0, 63,   1,   1,  0, 10,  1};
  localparam int VT[NV] = '{29268, 40888, 640, 4095, 129, 65, 64, 1290, 4097};

  // reference select table: select, tx, expected divisor
  localparam int NR = 8;
  localparam int RS[NR] = '{1, 2, 3, 4, 5, 6, 0, 0};
  localparam int RT[NR] = '{1, 1, 1, 1, 1, 1, 1, 0};
  localparam int RD[NR] = '{3168, 2640, 2112, 3312, 2760, 2208, 3168, 2112};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic meas_vco(output int cyc, output int mods, output int total);
    cyc = 0; mods = 0; total = 0;
    do @(negedge pre_clk); while (!vco_pulse);
    do begin
      cyc++;
      mods += int'(mod_sel);
      total += mod_sel ? 65 : 64;
      @(negedge pre_clk);
    end while (!vco_pulse);
  endtask

  task automatic meas_ref(output int cyc, output int width_bad);
    cyc = 0; width_bad = 0;
    do @(negedge ref_clk); while (!ref_pulse);
    do begin
      cyc++;
      @(negedge ref_clk);
      if (cyc == 1 && ref_pulse) width_bad = 1;
    end while (!ref_pulse);
  endtask

  always @(posedge ref_clk) begin
    ref_cycles++;
    if (ref_cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", ref_cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc, mods, total, wb, bad;
    // R8 reset state
    #40;
    check(!mod_sel && !vco_pulse && !ref_pulse, "R8", {mod_sel, vco_pulse, ref_pulse}, 0);
    @(negedge ref_clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge pre_clk);
      n_v = 10'(VN[i]); a_v = 6'(VA[i]);
      meas_vco(cyc, mods, total);
      check(total == VT[i], "R1 total division", total, VT[i]);
      check(mods == VA[i], "R2 swallow cycles", mods, VA[i]);
      check(cyc == VN[i], "R3 pulse spacing", cyc, VN[i]);
    end

    // R4: invalid pairs keep last loaded N=64, A=1
    @(negedge pre_clk); n_v = 10'd5; a_v = 6'd9;
    meas_vco(cyc, mods, total);
    check(total == 4097 && cyc == 64, "R4 A>N ignored", total, 4097);
    @(negedge pre_clk); n_v = 10'd0; a_v = 6'd0;
    meas_vco(cyc, mods, total);
    check(total == 4097 && mods == 1, "R4 N=0 ignored", total, 4097);

    for (int j = 0; j < NR; j++) begin
      @(negedge ref_clk);
      sel = 3'(RS[j]); tx = RT[j][0];
      meas_ref(cyc, wb);
      if (RS[j] == 0) check(cyc == RD[j], "R6 path divisor", cyc, RD[j]);
      else            check(cyc == RD[j], "R5 ref divisor", cyc, RD[j]);
      check(wb == 0, "R9 ref pulse width", wb, 0);
    end

    // R7 disabled channel
    @(negedge ref_clk); sel = 3'd7;
    @(negedge ref_clk);
    check(chan_off == 1'b1, "R7 flag", chan_off, 1);
    bad = 0;
    for (int k = 0; k < 7000; k++) begin
      @(negedge ref_clk);
      if (ref_pulse || vco_pulse) bad++;
    end
    check(bad == 0, "R7 pulses held low", bad, 0);
    @(negedge ref_clk); sel = 3'd2;
    @(negedge ref_clk);
    check(chan_off == 1'b0, "R7 flag cleared", chan_off, 0);
    meas_ref(cyc, wb);
    meas_ref(cyc, wb);
    check(cyc == 2640, "R7 recovery divisor", cyc, 2640);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule